// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block runs the host side of a four-wire serial programming link: a target reset pin, a serial clock, a data-out line and a data-in line. When `start` is pulsed, it holds the target in reset with the serial clock low and waits a settling time. It then sends the four-byte enable command and checks the reply. The target repeats the second enable byte while the third byte is going out. If that reply is wrong, the host finishes the command, pulses reset high, lets the target settle again and repeats the enable. It gives up with an error after a set number of attempts.

Once the link is in step, the block asks for one page of sixteen 16-bit words over a valid/ready handshake. Each word goes into the target's page buffer as two load commands, low byte first. After the last word, the block sends a commit command that carries the page address, stays silent for the flash write time, releases reset and pulses `done`. Opcodes, timing constants, the attempt limit and the clock divider are parameters.

Top module: `prog_link_host`

## Requirements
- R1: While `rst_n` is low and after it is released with no start, `tgt_rst`, `sck`, `busy`, `word_ready`, `done` and `err` are all low.
- R2: A `start` seen while idle drives `tgt_rst` and `sck` low at the next edge. The first rising `sck` edge comes exactly `SETTLE_CYC + HALF_SCK` clock cycles after the start edge.
- R3: Every command is exactly four bytes, sent most significant bit first. `mosi` never changes while `sck` is high, so the target samples it on the rising edge. The enable command is 0xAC, 0x53, 0x00, 0x00.
- R4: The host samples `miso` on each falling `sck` edge. An enable attempt succeeds only if the byte received during the third enable byte equals 0x53.
- R5: A failed enable attempt still sends all four bytes. `tgt_rst` then goes high for exactly `PULSE_CYC` cycles with `sck` low, and the enable is retried after a new settling wait.
- R6: After `MAX_TRIES` failed attempts, `err` rises and `busy` falls. No word is requested and exactly `4*MAX_TRIES` bytes have been sent.
- R7: `word_ready` is high only while the block waits for a word. Each valid-and-ready cycle takes one word, and exactly 16 words are taken per page.
- R8: Word i with data d is sent as {0x40, 0x00, i, d[7:0]} followed by {0x48, 0x00, i, d[15:8]}, where i is the 4-bit index zero-extended to a byte.
- R9: After the 16th word the block sends the commit command {0x4C, A[15:8], A[7:0], 0x00}, where A is `page_num` shifted left by 4.
- R10: After the last falling `sck` edge of the commit, the link stays quiet for exactly `WRITE_CYC` cycles. Then `done` pulses for one cycle, `busy` falls and `tgt_rst` goes high.
- R11: Every high phase of `sck` lasts exactly `HALF_SCK` clock cycles.
- R12: `start` and `page_num` are ignored while `busy` is high. The commit address is the page number captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming session (idle only) |
| page_num | input | PAGE_BITS | Page to program, captured at start |
| word_data | input | 16 | Page word offered by the data source |
| word_valid | input | 1 | `word_data` is valid |
| word_ready | output | 1 | Block accepts a word this cycle |
| tgt_rst | output | 1 | Target reset pin level |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| busy | output | 1 | A session is in progress |
| done | output | 1 | One-cycle pulse when a page has been committed |
| err | output | 1 | Enable failed on every allowed attempt; held until the next start |

## Verification
The bench uses a target model that returns the previous byte and can spoil its replies for a chosen number of enable attempts. This exercises a clean first attempt, recovery on the second and third attempts, and total failure. A design that checked the wrong reply byte, cut a failed command short or skipped the reset pulse would send the wrong number of bytes or pulses, or would never reach the page load. Byte-level comparison of every load and commit catches a design that swaps low and high bytes or misplaces the address bits. Exact cycle distances catch a settle or write wait that is off by one. A second start pulsed in the middle of a session, with a different page, shows whether the captured page can be overwritten.

// File: rtl/prog_link_host.sv
module prog_link_host #(
  parameter int HALF_SCK   = 4,
  parameter int SETTLE_CYC = 4_000_000,
  parameter int PULSE_CYC  = 16,
  parameter int WRITE_CYC  = 900_000,
  parameter int MAX_TRIES  = 4,
  parameter int PAGE_WORDS = 16,
  parameter int PAGE_BITS  = 6,
  parameter logic [7:0] OP_EN     = 8'hAC,
  parameter logic [7:0] EN_ECHO   = 8'h53,
  parameter logic [7:0] OP_LD_LO  = 8'h40,
  parameter logic [7:0] OP_LD_HI  = 8'h48,
  parameter logic [7:0] OP_COMMIT = 8'h4C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PAGE_BITS-1:0] page_num,
  input  logic [15:0]          word_data,
  input  logic                 word_valid,
  output logic                 word_ready,
  output logic                 tgt_rst,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);
  localparam int IDX_W = $clog2(PAGE_WORDS);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [31:0] HALF_END   = 32'(HALF_SCK - 1);
  localparam logic [31:0] SETTLE_END = 32'(SETTLE_CYC - 1);
  localparam logic [31:0] PULSE_END  = 32'(PULSE_CYC - 1);
  localparam logic [31:0] WRITE_END  = 32'(WRITE_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SEND, S_PULSE, S_WORD, S_WRITE} st_t;
  typedef enum logic [1:0] {K_EN, K_LO, K_HI, K_COMMIT} kind_t;

  st_t                  st;
  kind_t                kind;
  logic [31:0]          tmr;
  logic [2:0]           bit_i;
  logic [1:0]           byte_i;
  logic [7:0]           tx_sh;
  logic [6:0]           rx_sh;
  logic                 sck_r, rst_pin, echo_ok, err_r, done_r;
  logic [IDX_W-1:0]     word_i;
  logic [15:0]          word_q;
  logic [PAGE_BITS-1:0] page_q;
  logic [TRY_W-1:0]     tries;
  logic [15:0]          caddr;
  logic [7:0]           rx_next;
  logic                 half_end;

  assign caddr    = 16'({page_q, {IDX_W{1'b0}}});
  assign rx_next  = {rx_sh, miso};
  assign half_end = tmr == HALF_END;

  assign word_ready = st == S_WORD;
  assign busy       = st != S_IDLE;
  assign tgt_rst    = rst_pin;
  assign sck        = sck_r;
  assign mosi       = tx_sh[7];
  assign done       = done_r;
  assign err        = err_r;

  function automatic logic [7:0] cmd_byte(input kind_t k, input logic [1:0] i,
                                          input logic [IDX_W-1:0] w, input logic [15:0] d,
                                          input logic [15:0] ca);
    logic [31:0] c;
    case (k)
      K_EN:    c = {OP_EN, EN_ECHO, 16'h0000};
      K_LO:    c = {OP_LD_LO, 8'h00, 8'(w), d[7:0]};
      K_HI:    c = {OP_LD_HI, 8'h00, 8'(w), d[15:8]};
      default: c = {OP_COMMIT, ca, 8'h00};
    endcase
    case (i)
      2'd0:    return c[31:24];
      2'd1:    return c[23:16];
      2'd2:    return c[15:8];
      default: return c[7:0];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_EN; tmr <= '0; bit_i <= '0; byte_i <= '0;
      tx_sh <= '0; rx_sh <= '0; sck_r <= 1'b0; rst_pin <= 1'b0; echo_ok <= 1'b0;
      err_r <= 1'b0; done_r <= 1'b0; word_i <= '0; word_q <= '0; page_q <= '0; tries <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_SETTLE; tmr <= '0; rst_pin <= 1'b0; sck_r <= 1'b0;
            page_q <= page_num; tries <= '0; err_r <= 1'b0;
          end
        S_SETTLE:
          if (tmr == SETTLE_END) begin
            st <= S_SEND; kind <= K_EN; tx_sh <= OP_EN;
            byte_i <= '0; bit_i <= '0; tmr <= '0;
          end else tmr <= tmr + 32'd1;
        S_PULSE:
          if (tmr == PULSE_END) begin
            rst_pin <= 1'b0; st <= S_SETTLE; tmr <= '0;
          end else tmr <= tmr + 32'd1;
        S_WORD:
          if (word_valid) begin
            word_q <= word_data; kind <= K_LO; tx_sh <= OP_LD_LO; st <= S_SEND; tmr <= '0;
          end
        S_WRITE:
          if (tmr == WRITE_END) begin
            st <= S_IDLE; done_r <= 1'b1; rst_pin <= 1'b1;
          end else tmr <= tmr + 32'd1;
        S_SEND:
          if (!half_end) tmr <= tmr + 32'd1;
          else begin
            tmr <= '0;
            if (!sck_r) sck_r <= 1'b1;
            else begin
              sck_r <= 1'b0;
              rx_sh <= rx_next[6:0];
              tx_sh <= {tx_sh[6:0], 1'b0};
              bit_i <= bit_i + 3'd1;
              if (bit_i == 3'd7) begin
                if (kind == K_EN && byte_i == 2'd2) echo_ok <= rx_next == EN_ECHO;
                if (byte_i != 2'd3) begin
                  byte_i <= byte_i + 2'd1;
                  tx_sh  <= cmd_byte(kind, byte_i + 2'd1, word_i, word_q, caddr);
                end else begin
                  byte_i <= '0;
                  case (kind)
                    K_EN:
                      if (echo_ok) begin
                        st <= S_WORD; word_i <= '0;
                      end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                        err_r <= 1'b1; st <= S_IDLE; rst_pin <= 1'b1;
                      end else begin
                        tries <= tries + TRY_W'(1); rst_pin <= 1'b1; st <= S_PULSE;
                      end
                    K_LO: begin
                      kind <= K_HI; tx_sh <= OP_LD_HI;
                    end
                    K_HI:
                      if (word_i == IDX_W'(PAGE_WORDS - 1)) begin
                        kind <= K_COMMIT; tx_sh <= OP_COMMIT;
                      end else begin
                        word_i <= word_i + IDX_W'(1); st <= S_WORD;
                      end
                    default: st <= S_WRITE;
                  endcase
                end
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module prog_link_host_chk #(
  parameter int HALF_SCK = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sck,
  input logic mosi,
  input logic tgt_rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic word_ready,
  input logic word_valid
);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && !tgt_rst && !sck);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  // R5
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tgt_rst |-> !sck);
  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !word_ready);
  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready && word_valid |=> !word_ready);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && tgt_rst);
  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  sck_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HALF_SCK > 1) && (sck != $past(sck)) |=> $stable(sck));
endmodule

bind prog_link_host prog_link_host_chk #(.HALF_SCK(HALF_SCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst),
  .busy(busy), .done(done), .err(err), .word_ready(word_ready), .word_valid(word_valid));

// File: tb/prog_link_host_bench.sv
`timescale 1ns/1ps
module prog_link_host_bench;
  localparam int HALF = 2, SETTLE = 40, PULSE = 6, WRITE = 100, TRIES = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, word_valid = 1'b0;
  logic [5:0] page_num = '0;
  logic [15:0] word_data = '0;
  logic miso, word_ready, tgt_rst, sck, mosi, busy, done, err;

  prog_link_host #(.HALF_SCK(HALF), .SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE),
                   .WRITE_CYC(WRITE), .MAX_TRIES(TRIES)) u_prog_link_host (
    .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .tgt_rst(tgt_rst), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done), .err(err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target model: replies with the previous byte, optionally inverted
  logic [7:0] t_rx = '0, t_tx = '0;
  int t_cnt = 0, nlog = 0, pulses_seen = 0, bad_lim = 0;
  logic [7:0] log_b [1024];
  always @(posedge sck) begin
    t_rx = {t_rx[6:0], mosi};
    t_cnt++;
    if (t_cnt == 8) begin
      t_cnt = 0;
      if (nlog < 1024) log_b[nlog] = t_rx;
      nlog++;
    end
  end
  always @(negedge sck) begin
    if (t_cnt == 0) t_tx = t_rx;
    else t_tx = {t_tx[6:0], 1'b0};
  end
  always @(posedge tgt_rst) pulses_seen++;
  assign miso = t_tx[7] ^ (pulses_seen < bad_lim);

  // port monitor
  logic p_sck = 0, p_mosi = 0, armed = 0;
  int start_at = 0, first_rise = 0, last_fall = 0, done_at = 0, dones = 0, hs = 0;
  int hcnt = 0, half_bad = 0, hi_bad = 0, pw_cur = 0, pw_n = 0, pw_bad = 0, psck_bad = 0;
  always @(posedge clk) begin
    if (start && !busy && rst_n) begin start_at = cyc; armed = 1; end
    if (sck && !p_sck && armed) begin first_rise = cyc; armed = 0; end
    if (!sck && p_sck) last_fall = cyc;
    if (sck && mosi != p_mosi) hi_bad++;
    if (sck) hcnt++;
    else if (hcnt > 0) begin if (hcnt != HALF) half_bad++; hcnt = 0; end
    if (tgt_rst && busy) begin pw_cur++; if (sck) psck_bad++; end
    else if (pw_cur > 0) begin if (pw_cur != PULSE) pw_bad++; pw_n++; pw_cur = 0; end
    if (done) begin dones++; done_at = cyc; end
    if (word_valid && word_ready) hs++;
    p_sck = sck; p_mosi = mosi;
  end

  // word source
  logic feed_on = 0;
  logic [15:0] seed = '0;
  int hs_base = 0;
  function automatic logic [15:0] pat(input logic [15:0] s, input int i);
    return s ^ 16'(i * 4919);
  endfunction
  always @(negedge clk) begin
    word_valid = feed_on;
    word_data  = pat(seed, hs - hs_base);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({tgt_rst, sck, busy, word_ready, done, err} == 6'b0, "R1", "outputs in reset",
        {tgt_rst, sck, busy, word_ready, done, err}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({tgt_rst, sck, busy, word_ready, done, err} == 6'b0, "R1", "outputs idle",
        {tgt_rst, sck, busy, word_ready, done, err}, 0);
  endtask

  task automatic t_session(input logic [5:0] pg, input logic [15:0] sd, input int bad,
                           input bit mid_start, input string name);
    int p0 = pw_n, pb0 = pw_bad, hb0 = half_bad, mb0 = hi_bad, sb0 = psck_bad;
    int d0 = dones, h0 = hs, lg0 = nlog, n = 0, base;
    bit ok_exp = bad < TRIES;
    logic [15:0] ca;
    $display("scenario %s", name);
    bad_lim = pulses_seen + bad;
    seed = sd; hs_base = hs;
    @(negedge clk); page_num = pg; start = 1;
    @(negedge clk); start = 0; feed_on = 1;
    chk(!tgt_rst && !sck && busy, "R2", "reset and clock low after start",
        {tgt_rst, sck, busy}, 3'b001);
    while (dones == d0 && !err && n < 30000) begin
      @(negedge clk); n++;
      if (mid_start && n == 300) begin start = 1; page_num = ~pg; end
      else start = 0;
    end
    feed_on = 0;
    @(negedge clk);
    chk(first_rise - start_at == SETTLE + HALF + 1, "R2", "settle delay before first edge",
        first_rise - start_at, SETTLE + HALF + 1);
    chk(half_bad == hb0, "R11", "sck high phase length", half_bad - hb0, 0);
    chk(hi_bad == mb0, "R3", "mosi changed while sck high", hi_bad - mb0, 0);
    chk(psck_bad == sb0, "R5", "sck high during reset pulse", psck_bad - sb0, 0);
    for (int a = 0; a < (ok_exp ? bad + 1 : TRIES); a++)
      chk({log_b[lg0+4*a], log_b[lg0+4*a+1], log_b[lg0+4*a+2], log_b[lg0+4*a+3]} == 32'hAC530000,
          "R3", "enable command bytes",
          {log_b[lg0+4*a], log_b[lg0+4*a+1], log_b[lg0+4*a+2], log_b[lg0+4*a+3]}, 32'hAC530000);
    if (ok_exp) begin
      chk(dones == d0 + 1 && !err, "R4", "session completed after echo", {dones - d0, err}, 2);
      chk(pw_n - p0 == bad && pw_bad == pb0, "R5", "retry reset pulses",
          pw_n - p0 + 100 * (pw_bad - pb0), bad);
      chk(hs - h0 == 16, "R7", "words taken", hs - h0, 16);
      chk(nlog - lg0 == 4 * (bad + 1) + 132, "R3", "byte count", nlog - lg0, 4 * (bad + 1) + 132);
      base = lg0 + 4 * (bad + 1);
      for (int i = 0; i < 16; i++) begin
        logic [15:0] d = pat(sd, i);
        logic [63:0] e = {8'h40, 8'h00, 8'(i), d[7:0], 8'h48, 8'h00, 8'(i), d[15:8]};
        logic [63:0] g;
        for (int k = 0; k < 8; k++) g[63-8*k -: 8] = log_b[base + 8*i + k];
        chk(g == e, "R8", "word load pair", g, e);
      end
      ca = 16'(pg) << 4;
      chk({log_b[base+128], log_b[base+129], log_b[base+130], log_b[base+131]} ==
          {8'h4C, ca, 8'h00}, mid_start ? "R12" : "R9", "commit command",
          {log_b[base+128], log_b[base+129], log_b[base+130], log_b[base+131]}, {8'h4C, ca, 8'h00});
      chk(done_at - last_fall == WRITE, "R10", "write wait", done_at - last_fall, WRITE);
      chk(!busy && tgt_rst && !done, "R10", "state after done", {busy, tgt_rst, done}, 3'b010);
    end else begin
      chk(err && !busy, "R6", "error after all attempts", {err, busy}, 2'b10);
      chk(hs == h0, "R6", "no word requested", hs - h0, 0);
      chk(nlog - lg0 == 4 * TRIES, "R5", "all enable bytes sent", nlog - lg0, 4 * TRIES);
      chk(pw_n - p0 == TRIES - 1 && pw_bad == pb0, "R5", "reset pulses between attempts",
          pw_n - p0, TRIES - 1);
    end
  endtask

  initial begin
    t_reset();
    t_session(6'h05, 16'hA5C3, 0, 0, "clean enable");
    t_session(6'h2A, 16'h1E0F, 1, 1, "one retry with ignored start");
    t_session(6'h11, 16'h7777, TRIES, 0, "enable never echoes");
    t_session(6'h3F, 16'hFFFF, TRIES - 1, 0, "last attempt succeeds, top page");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule